// File: doc/BRIEF.md
# Chaotic Keystream Selector and Combiner

This block is the final stage of a synchronous stream cipher built on two chaotic recurrences. On every accepted step it takes the present outputs of the two chaotic cells (one from a skew-tent recurrence, one from a piecewise-linear recurrence), turns them into a single N-bit keystream word and XORs that word into an N-bit data word. The same block encrypts at the sender and decrypts at the receiver. Both ends must hold the same cell sequence.

Two ways of forming the keystream are available. In selector mode, the block XORs the cell outputs of the previous accepted step and compares the result against a half-range threshold. That comparison picks which of the two present cell outputs becomes the keystream. In XOR mode, the keystream is the XOR of the two present cell outputs. The previous-step history is kept across mode changes. Results are registered and appear one clock after the accepted input, so the block delivers N bits per clock.

Top module: `chaos_ks_combiner`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `key_out` and `data_out` are zero, and the stored previous-step cell values are zero.
- R2: With `mode`=0 (selector), let C be the XOR of the `cell_s` and `cell_p` values of the last accepted word. The keystream is `cell_s` when 0 < C <= 2^(N-1), and `cell_p` otherwise.
- R3: The first accepted word after reset sees C = 0. In selector mode it therefore uses `cell_p`.
- R4: With `mode`=1 (XOR), the keystream is `cell_s` XOR `cell_p` of the same word.
- R5: `data_out` equals the accepted `data_in` XOR the keystream. Feeding the ciphertext back through a freshly reset block with the same cell sequence returns the plaintext.
- R6: `out_valid` is high exactly one clock after a cycle with `in_valid` high. It is low one clock after a cycle with `in_valid` low.
- R7: Cycles with `in_valid` low leave `key_out`, `data_out` and the stored previous-step values unchanged, whatever the cell and data inputs carry.
- R8: A change of `mode` applies from the next accepted word. Words accepted in either mode update the stored previous-step values.
- R9: Threshold edges in selector mode: C = 2^(N-1) selects `cell_s`. C = 2^(N-1)+1 and C = all ones both select `cell_p`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the present cell outputs and data word |
| mode | input | 1 | 0 = threshold selector, 1 = XOR of cells |
| cell_s | input | N | Present skew-tent cell output |
| cell_p | input | N | Present piecewise-linear cell output |
| data_in | input | N | Plaintext or ciphertext word |
| key_out | output | N | Keystream word of the last accepted step |
| data_out | output | N | Data XOR keystream of the last accepted step |
| out_valid | output | 1 | Outputs belong to the word accepted one clock earlier |

## Verification
A corrupted previous-step register does not show at the ports on the word that stores it. In selector mode it shows on the next accepted word, as the wrong cell being chosen, so `key_out` and `data_out` differ from the model one clock after that word. XOR-mode words hide such corruption entirely. For that reason the sequences mix the modes, insert idle gaps carrying garbage, and steer the control value onto the threshold edges. A fault on the valid path shows at once as `out_valid` out of step with the scoreboard, or as outputs that change during gaps.

// File: rtl/ks_pkg.sv
package ks_pkg;
  typedef enum logic {
    KS_SELECT = 1'b0,
    KS_XOR    = 1'b1
  } ks_mode_e;
endpackage

// File: rtl/ks_history.sv
module ks_history #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] cell_s,
  input  logic [N-1:0] cell_p,
  output logic [N-1:0] prev_s,
  output logic [N-1:0] prev_p
);
  logic [N-1:0] prev_s_nxt;
  logic [N-1:0] prev_p_nxt;

  always_comb begin
    prev_s_nxt = prev_s;
    prev_p_nxt = prev_p;
    if (en) begin
      prev_s_nxt = cell_s;
      prev_p_nxt = cell_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_s <= '0;
      prev_p <= '0;
    end else begin
      prev_s <= prev_s_nxt;
      prev_p <= prev_p_nxt;
    end
  end

  AST_HIST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(prev_s) && $stable(prev_p))); // R7
  AST_HIST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (prev_s == $past(cell_s) && prev_p == $past(cell_p))); // R8
endmodule

// File: rtl/ks_select.sv
module ks_select
  import ks_pkg::*;
#(
  parameter int N = 32
) (
  input  ks_mode_e     mode,
  input  logic [N-1:0] prev_s,
  input  logic [N-1:0] prev_p,
  input  logic [N-1:0] cell_s,
  input  logic [N-1:0] cell_p,
  output logic [N-1:0] key
);
  localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] ctrl;
  logic         pick_s;

  always_comb begin
    ctrl   = prev_s ^ prev_p;
    pick_s = (ctrl != '0) && (ctrl <= HALF);
    unique case (mode)
      KS_XOR:    key = cell_s ^ cell_p;
      default:   key = pick_s ? cell_s : cell_p;
    endcase
  end

  always_comb begin
    if (mode == KS_SELECT && ctrl == '0)
      AST_ZERO_CTRL_PICKS_P: assert (key == cell_p); // R3
  end
endmodule

// File: rtl/ks_combine.sv
module ks_combine #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] key,
  input  logic [N-1:0] data,
  output logic [N-1:0] key_q,
  output logic [N-1:0] data_q,
  output logic         vld_q
);
  logic [N-1:0] key_nxt;
  logic [N-1:0] data_nxt;

  always_comb begin
    key_nxt  = key_q;
    data_nxt = data_q;
    if (en) begin
      key_nxt  = key;
      data_nxt = data ^ key;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      key_q  <= key_nxt;
      data_q <= data_nxt;
      vld_q  <= en;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(key_q) && $stable(data_q))); // R7
  AST_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((data_q ^ key_q) == $past(data))); // R5
endmodule

// File: rtl/chaos_ks_combiner.sv
module chaos_ks_combiner
  import ks_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         mode,
  input  logic [N-1:0] cell_s,
  input  logic [N-1:0] cell_p,
  input  logic [N-1:0] data_in,
  output logic [N-1:0] key_out,
  output logic [N-1:0] data_out,
  output logic         out_valid
);
  logic         rst_meta;
  logic         rst_sync_n;
  logic [N-1:0] prev_s;
  logic [N-1:0] prev_p;
  logic [N-1:0] key_w;
  ks_mode_e     mode_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign mode_e = ks_mode_e'(mode);

  ks_history #(.N(N)) u_hist (
    .clk(clk), .rst_n(rst_sync_n), .en(in_valid),
    .cell_s(cell_s), .cell_p(cell_p),
    .prev_s(prev_s), .prev_p(prev_p)
  );

  ks_select #(.N(N)) u_sel (
    .mode(mode_e), .prev_s(prev_s), .prev_p(prev_p),
    .cell_s(cell_s), .cell_p(cell_p), .key(key_w)
  );

  ks_combine #(.N(N)) u_comb (
    .clk(clk), .rst_n(rst_sync_n), .en(in_valid),
    .key(key_w), .data(data_in),
    .key_q(key_out), .data_q(data_out), .vld_q(out_valid)
  );

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R6
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R6
  AST_XOR_MODE_KEY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && mode) |=> (key_out == $past(cell_s ^ cell_p))); // R4
  AST_SELECT_FROM_CELLS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !mode) |=> (key_out == $past(cell_s) || key_out == $past(cell_p))); // R2
  always_comb begin
    if (!rst_n)
      AST_RESET_QUIET: assert (!out_valid); // R1
  end
endmodule

// File: tb/sim_chaos_ks_combiner.sv
`timescale 1ns/1ps
module sim_chaos_ks_combiner;
  localparam int N = 32;
  localparam logic [N-1:0] HALF = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n, in_valid, mode;
  logic [N-1:0] cell_s, cell_p, data_in, key_out, data_out;
  logic out_valid;

  always #2.5 clk = ~clk;

  chaos_ks_combiner #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .cell_s(cell_s), .cell_p(cell_p), .data_in(data_in),
    .key_out(key_out), .data_out(data_out), .out_valid(out_valid)
  );

  int total = 0;
  int bad = 0;
  logic [N-1:0] m_ps, m_pp;
  logic [N-1:0] q_key[$];
  logic [N-1:0] q_res[$];
  string        q_tag[$];
  logic [N-1:0] cap[$];
  logic [N-1:0] last_key, last_res;
  logic seen = 1'b0;
  logic mon_on = 1'b0;
  logic vld_d = 1'b0;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_key(input logic m, input logic [N-1:0] ps, pp, s, p);
    logic [N-1:0] c;
    c = ps ^ pp;
    if (m) return s ^ p;
    if (c >= 1 && c <= HALF) return s;
    return p;
  endfunction

  task automatic send(input logic m, input logic [N-1:0] s, p, d, input string tag,
                      input logic use_exp_res, input logic [N-1:0] exp_res);
    logic [N-1:0] k;
    @(negedge clk);
    in_valid = 1'b1; mode = m; cell_s = s; cell_p = p; data_in = d;
    k = model_key(m, m_ps, m_pp, s, p);
    q_key.push_back(k);
    q_res.push_back(use_exp_res ? exp_res : (d ^ k));
    q_tag.push_back(tag);
    m_ps = s; m_pp = p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; mode = $urandom; cell_s = $urandom; cell_p = $urandom; data_in = $urandom;
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    mon_on = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0;
    m_ps = '0; m_pp = '0; seen = 1'b0;
    q_key.delete(); q_res.delete(); q_tag.delete();
    repeat (2) @(negedge clk);
    chk("R1 out_valid in reset", {31'b0, out_valid}, '0);
    chk("R1 key_out in reset", key_out, '0);
    chk("R1 data_out in reset", data_out, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out_valid after reset", {31'b0, out_valid}, '0);
    chk("R1 data_out after reset", data_out, '0);
    mon_on = 1'b1;
  endtask

  // monitor: pops expectations as results appear, checks hold on idle cycles
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q_key.size() == 0) begin
          chk("R6 unexpected out_valid", 32'd1, 32'd0);
        end else begin
          string t;
          t = q_tag.pop_front();
          chk({t, " key"}, key_out, q_key.pop_front());
          chk({t, " result"}, data_out, q_res.pop_front());
          cap.push_back(data_out);
        end
        last_key = key_out; last_res = data_out; seen = 1'b1;
      end else if (seen) begin
        chk("R7 key hold on idle", key_out, last_key);
        chk("R7 result hold on idle", data_out, last_res);
      end
      if (vld_d && !out_valid) chk("R6 missing out_valid", 32'd0, 32'd1);
    end
    vld_d = in_valid && rst_n && mon_on;
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] pt[$];
    logic [N-1:0] cs[$];
    logic [N-1:0] cp[$];
    logic         md[$];
    rst_n = 1'b0; in_valid = 1'b0; mode = 1'b0;
    cell_s = '0; cell_p = '0; data_in = '0;
    do_reset();

    // R3 first word picks cell_p; this word leaves C = HALF
    send(1'b0, HALF, 32'h0, 32'h1234_5678, "R3 first word", 1'b0, '0);
    // R9 C == HALF picks cell_s; leave C = HALF+1
    send(1'b0, HALF | 32'h1, 32'h0, 32'hCAFE_F00D, "R9 C=HALF", 1'b0, '0);
    // R9 C == HALF+1 picks cell_p; leave C = all ones
    send(1'b0, 32'hFFFF_0000, 32'h0000_FFFF, 32'h0BAD_BEEF, "R9 C=HALF+1", 1'b0, '0);
    // R9 all ones picks cell_p; leave C = 1
    send(1'b0, 32'h1, 32'h0, 32'h5555_AAAA, "R9 C=ones", 1'b0, '0);
    // R2 C = 1 picks cell_s
    send(1'b0, 32'h0F0F_0F0F, 32'h7777_0000, 32'h0, "R2 C=1", 1'b0, '0);
    idle(3);
    // R7 idle garbage ignored: history still from last word
    send(1'b0, 32'hDEAD_0001, 32'h1111_2222, 32'hFFFF_FFFF, "R7 after gap", 1'b0, '0);
    // R4 xor mode and R8 mode switch keeps/updates history
    send(1'b1, 32'h8000_0000, 32'h0000_0000, 32'hA5A5_A5A5, "R4 xor", 1'b0, '0);
    send(1'b0, 32'h2222_2222, 32'h3333_3333, 32'h1357_9BDF, "R8 select after xor", 1'b0, '0);
    idle(1);
    for (int i = 0; i < 200; i++) begin
      send(1'(($urandom % 3) == 0), $urandom, $urandom, $urandom, "R2 random", 1'b0, '0);
      if (($urandom % 5) == 0) idle(1 + $urandom % 3);
    end
    idle(3);

    // R5 round trip through a freshly reset block
    cap.delete();
    do_reset();
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] v;
      v = $urandom;
      pt.push_back(v); cs.push_back($urandom); cp.push_back($urandom); md.push_back(1'($urandom));
      send(md[i], cs[i], cp[i], v, "R5 encrypt", 1'b0, '0);
    end
    idle(3);
    do_reset();
    for (int i = 0; i < 40; i++) begin
      send(md[i], cs[i], cp[i], cap[i], "R5 decrypt", 1'b1, pt[i]);
    end
    idle(3);
    chk("R5 queue drained", q_key.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule